// File: doc/BRIEF.md
# Fractional 25/16 Pulse Divider

This block thins a stream of single-cycle input strobes so that 16 of every 25 strobes pass and 9 are removed. The result is an output rate of 16/25 of the input rate. Everything runs in one clock domain. An input pulse is one cycle with `in_stb` high. `out_stb` is high in that same cycle only when the pulse is kept. The nine removed pulses are spread through the 25-pulse window rather than bunched together. This suits a block that follows a fixed prescaler, where the overall division ratio has to come out exact.

Two keep/drop schemes are available, and the applied scheme is held in a two-state machine.
- **SCHEME_CASCADE** uses two chained mod-5 swallow stages. Each stage removes the pulse that arrives when its count is 4.
- **SCHEME_ACCUM** uses a mod-25 phase accumulator that adds 9 per pulse and drops the pulse whenever the sum overflows.

The machine has two transitions:
- **STAY**: the machine keeps its state on every cycle except the last pulse of a window.
- **SWITCH**: the machine loads `mode_req` on the last pulse of a window, so each full window is produced by one scheme only.

Every counter is kept running in both modes. All of them return to zero together at each window boundary.

Top module: `frac_pulse_divider`

## Requirements
- R1: Every complete window of 25 input pulses, counted from reset, yields exactly 16 output pulses, in either scheme.
- R2: `out_stb` is high only in a cycle where `in_stb` is high. The keep decision appears in that same cycle with no added latency.
- R3: With `mode_req`=0 (cascade), the pulses at window positions 4, 5, 9, 11, 14, 17, 19, 23 and 24 are dropped and all other positions are kept.
- R4: In cascade mode, the second stage advances only on pulses the first stage kept. Idle cycles between strobes advance no counter, so arbitrary gaps leave the R3 pattern unchanged.
- R5: With `mode_req`=1 (accumulator), the pulses at positions 2, 5, 8, 11, 13, 16, 19, 22 and 24 are dropped, and no two consecutive input pulses are both dropped.
- R6: A synchronous reset clears all counters and the accumulator. `win_pos` reads 0, `out_stb` is low, and the first pulse after reset is kept in both modes.
- R7: `win_pos` gives the 0..24 index of the current pulse in its window. It increments by one per input pulse, wraps from 24 to 0, and holds during idle cycles.
- R8: A change of `mode_req` takes effect only from position 0 of the next window. The value sampled with the pulse at position 24 selects the scheme for the following window.
- R9: The scheme used for the first window after reset is the value of `mode_req` during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_stb | input | 1 | Input pulse strobe, one cycle per pulse |
| mode_req | input | 1 | Requested scheme: 0 cascade, 1 accumulator |
| out_stb | output | 1 | Kept-pulse strobe |
| win_pos | output | 5 | Index of the current pulse within its 25-pulse window |

## Verification
The bench first drives back-to-back strobes in each scheme. Because every position's keep/drop decision is compared, this separates the two drop patterns and any off-by-one in a counter. It then repeats both schemes with varying idle gaps between strobes. This exposes a counter that advances on clock cycles instead of pulses, or a second stage that counts raw input pulses. A mid-window change of `mode_req`, and resets with each request value, show whether the scheme switch waits for the window boundary and whether the pattern restarts at its known phase.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
    typedef enum logic {
        SCHEME_CASCADE = 1'b0,
        SCHEME_ACCUM   = 1'b1
    } scheme_e;
endpackage

// File: rtl/fpd_win_count.sv
module fpd_win_count #(
    parameter int WIN   = 25,
    parameter int POS_W = $clog2(WIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    output logic [POS_W-1:0] pos,
    output logic             last
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(WIN - 1);

    assign last = (pos == POS_LAST);

    always_ff @(posedge clk) begin
        if (rst)           pos <= '0;
        else if (stb)      pos <= last ? '0 : pos + 1'b1;
    end

    AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
        (stb && last) |=> (pos == '0)); // R7
    AST_POS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(pos)); // R7
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
        pos <= POS_LAST); // R7
endmodule

// File: rtl/fpd_swallow_stage.sv
module fpd_swallow_stage #(
    parameter int MOD = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_in,
    output logic stb_out
);
    localparam int CW = $clog2(MOD);
    localparam logic [CW-1:0] DROP_AT = CW'(MOD - 1);

    logic [CW-1:0] cnt;
    logic          at_drop;

    assign at_drop = (cnt == DROP_AT);
    assign stb_out = stb_in && !at_drop;

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (stb_in) cnt <= at_drop ? '0 : cnt + 1'b1;
    end

    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        stb_in |=> (cnt != $past(cnt))); // R4
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb_in |=> $stable(cnt)); // R4
endmodule

// File: rtl/fpd_phase_accum.sv
module fpd_phase_accum #(
    parameter int WIN  = 25,
    parameter int STEP = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic keep
);
    localparam int AW = $clog2(WIN) + 1;
    localparam logic [AW-1:0] WIN_V  = AW'(WIN);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] acc;
    logic [AW-1:0] sum;
    logic          ovf;
    logic          prev_drop;

    assign sum  = acc + STEP_V;
    assign ovf  = (sum >= WIN_V);
    assign keep = !ovf;

    always_ff @(posedge clk) begin
        if (rst)      acc <= '0;
        else if (stb) acc <= ovf ? sum - WIN_V : sum;
    end

    always_ff @(posedge clk) begin
        if (rst)      prev_drop <= 1'b0;
        else if (stb) prev_drop <= ovf;
    end

    AST_ACC_RANGE: assert property (@(posedge clk) disable iff (rst)
        acc < WIN_V); // R5
    AST_NO_DOUBLE_DROP: assert property (@(posedge clk) disable iff (rst)
        (stb && prev_drop) |-> keep); // R5
endmodule

// File: rtl/frac_pulse_divider.sv
module frac_pulse_divider
    import fpd_pkg::*;
#(
    parameter int WIN       = 25,
    parameter int KEEP      = 16,
    parameter int STAGE_MOD = 5,
    parameter int STAGES    = 2,
    parameter int POS_W     = $clog2(WIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_stb,
    input  logic             mode_req,
    output logic             out_stb,
    output logic [POS_W-1:0] win_pos
);
    localparam int STEP = WIN - KEEP;
    localparam int KW   = $clog2(WIN + 1);

    scheme_e          scheme_q, scheme_d;
    logic             win_last;
    logic [STAGES:0]  chain;
    logic             acc_keep;

    fpd_win_count #(.WIN(WIN), .POS_W(POS_W)) u_win (
        .clk(clk), .rst(rst), .stb(in_stb), .pos(win_pos), .last(win_last)
    );

    assign chain[0] = in_stb;
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        fpd_swallow_stage #(.MOD(STAGE_MOD)) u_stage (
            .clk(clk), .rst(rst), .stb_in(chain[g]), .stb_out(chain[g+1])
        );
    end

    fpd_phase_accum #(.WIN(WIN), .STEP(STEP)) u_acc (
        .clk(clk), .rst(rst), .stb(in_stb), .keep(acc_keep)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) scheme_q <= scheme_e'(mode_req);
        else     scheme_q <= scheme_d;
    end

    // next state: STAY, or SWITCH on the last pulse of a window
    always_comb begin
        scheme_d = scheme_q;
        unique case (scheme_q)
            SCHEME_CASCADE: if (in_stb && win_last) scheme_d = scheme_e'(mode_req);
            SCHEME_ACCUM:   if (in_stb && win_last) scheme_d = scheme_e'(mode_req);
            default:        scheme_d = SCHEME_CASCADE;
        endcase
    end

    // outputs
    always_comb begin
        out_stb = 1'b0;
        unique case (scheme_q)
            SCHEME_CASCADE: out_stb = chain[STAGES];
            SCHEME_ACCUM:   out_stb = in_stb && acc_keep;
            default:        out_stb = 1'b0;
        endcase
    end

    // per-window kept-pulse tally, used by the checks only
    logic [KW-1:0] win_keeps;
    always_ff @(posedge clk) begin
        if (rst)         win_keeps <= '0;
        else if (in_stb) win_keeps <= win_last ? '0 : win_keeps + KW'(out_stb);
    end

    AST_KEEP_COUNT: assert property (@(posedge clk) disable iff (rst)
        (in_stb && win_last) |-> ((win_keeps + KW'(out_stb)) == KW'(KEEP))); // R1
    AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> in_stb); // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(in_stb && win_last) |=> $stable(scheme_q)); // R8
endmodule

// File: tb/tb_frac_pulse_divider.sv
`timescale 1ns/1ps
module tb_frac_pulse_divider;
    typedef struct {
        bit    keep;
        int    pos;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_stb = 1'b0;
    logic       mode_req = 1'b0;
    logic       out_stb;
    logic [4:0] win_pos;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    exp_t  q[$];
    bit    exp_mode;
    int    exp_idx;
    bit    first_pend;
    string tag_ovr = "";
    int    dut_keeps = 0;

    always #10 clk = ~clk;

    frac_pulse_divider dut (
        .clk(clk), .rst(rst), .in_stb(in_stb), .mode_req(mode_req),
        .out_stb(out_stb), .win_pos(win_pos)
    );

    function automatic bit exp_keep(bit m, int i);
        if (!m) return !(i inside {4, 5, 9, 11, 14, 17, 19, 23, 24});
        return !(i inside {2, 5, 8, 11, 13, 16, 19, 22, 24});
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; in_stb = 1'b0;
        repeat (2) @(posedge clk);
        exp_mode = mode_req; exp_idx = 0; first_pend = 1'b1; dut_keeps = 0;
        #1 rst = 1'b0;
        @(negedge clk);
        check(win_pos == 5'd0, "R6", win_pos, 0);
        check(out_stb == 1'b0, "R6", out_stb, 0);
    endtask

    task automatic send(int gap);
        exp_t e;
        for (int k = 0; k < gap; k++) begin
            @(posedge clk); #1 in_stb = 1'b0;
        end
        @(posedge clk); #1 in_stb = 1'b1;
        e.keep = exp_keep(exp_mode, exp_idx);
        e.pos  = exp_idx;
        if (first_pend)       e.tag = "R6";
        else if (tag_ovr != "") e.tag = tag_ovr;
        else if (exp_mode)    e.tag = "R5";
        else                  e.tag = (gap > 0) ? "R4" : "R3";
        first_pend = 1'b0;
        q.push_back(e);
        if (exp_idx == 24) begin
            exp_idx = 0;
            exp_mode = mode_req;
        end else begin
            exp_idx++;
        end
    endtask

    task automatic idle();
        @(posedge clk); #1 in_stb = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (in_stb) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2", 0, 1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_stb == e.keep, e.tag, out_stb, e.keep);
                    check(win_pos == 5'(e.pos), "R7", win_pos, e.pos);
                    if (out_stb) dut_keeps++;
                    if (e.pos == 24) begin
                        check(dut_keeps == 16, "R1", dut_keeps, 16);
                        dut_keeps = 0;
                    end
                end
            end else begin
                check(out_stb == 1'b0, "R2", out_stb, 0);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mode_req = 1'b0;
        do_reset();
        // R3: cascade, back to back
        for (int i = 0; i < 50; i++) send(0);
        // R4 R7: cascade with idle gaps
        for (int i = 0; i < 50; i++) send((i * 7) % 3);
        // R8: request accumulator mid-window
        for (int i = 0; i < 10; i++) send(0);
        mode_req = 1'b1;
        tag_ovr = "R8";
        for (int i = 0; i < 15; i++) send(1);
        tag_ovr = "";
        // R5: accumulator back to back and with gaps
        for (int i = 0; i < 50; i++) send(0);
        for (int i = 0; i < 50; i++) send((i * 5) % 4);
        // R8: back to cascade mid-window
        for (int i = 0; i < 7; i++) send(0);
        mode_req = 1'b0;
        tag_ovr = "R8";
        for (int i = 0; i < 18; i++) send(0);
        tag_ovr = "";
        for (int i = 0; i < 25; i++) send(0);
        idle();
        // R9 R6: reset with accumulator requested, mid-window reset
        mode_req = 1'b1;
        do_reset();
        tag_ovr = "R9";
        for (int i = 0; i < 40; i++) send(i % 2);
        tag_ovr = "";
        idle();
        mode_req = 1'b0;
        do_reset();
        for (int i = 0; i < 25; i++) send(2);
        idle();
        repeat (3) @(posedge clk);
        check(q.size() == 0, "R2", q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule